// File: doc/BRIEF.md
# Instruction Fetch Front-End with Redirect

This block fetches instructions from an internal instruction store with one cycle of read latency. Each word is queued in a small buffer together with the address it was fetched from. An output register presents one instruction at a time to the back-end. The back-end takes a word in a cycle where `ins_valid` and `be_ready` are both high. While `be_ready` is low, the presented word is held.

A redirect pulse carries a target address and restarts fetch at that address. Everything already fetched is discarded. The first instruction from the new stream is presented after a fixed recovery sequence:

- the target is registered;
- the next cycle clears the buffer and reads the store;
- the word lands in the buffer;
- the word moves into the output register.

Reset acts as a redirect to address zero. The instruction store is a read-only model. Its contents are computed from the address, so a back-end can check every word it receives.

Top module: `ifetch_front`

## Requirements
- R1: While `rst_n` is low, `ins_valid` is 0. Call the first cycle after `rst_n` rises cycle 1. `ins_valid` is 0 in cycles 2 and 3, and in cycle 4 it is 1 with `ins_pc` = 0.
- R2: Call the cycle in which `redir` is high (with target `redir_pc` = A) cycle 0, and assume no further redirect. `ins_valid` is 0 in cycles 2 and 3. In cycle 4 it is 1 with `ins_pc` = A.
- R3: Whenever `ins_valid` is 1, `ins_word` equals the low DW bits of ((`ins_pc` zero-extended to 32 bits) × 0x9E3779B9, modulo 2^32) XOR 0x5A5A5A5A.
- R4: After a redirect to A, the successive accepted instructions carry addresses A, A+1, A+2, … with no gap and no repeat.
- R5: While `ins_valid` is 1 and `be_ready` is 0, and no flush is under way, `ins_valid`, `ins_word` and `ins_pc` keep their values in the next cycle.
- R6: An instruction is consumed only in a cycle where `ins_valid` and `be_ready` are both 1. Each fetched instruction is delivered exactly once.
- R7: After a redirect, no instruction fetched before it is ever presented, even when the buffer and output were full of old words.
- R8: Fetch addresses wrap from 2^AW−1 to 0.
- R9: With redirects in two consecutive cycles (A, then B), the later one wins. `ins_valid` is 0 in the second, third and fourth cycles after the first redirect. In the fifth it is 1 with `ins_pc` = B.
- R10: The buffer holds DEPTH entries and never exceeds that. Fetch stops advancing while it is full. After a long stall, DEPTH+1 instructions are delivered in consecutive cycles once `be_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, behaves as a redirect to 0 |
| redir | input | 1 | Redirect request, sampled on the rising edge |
| redir_pc | input | AW | Redirect target address |
| be_ready | input | 1 | Back-end can accept the presented instruction |
| ins_valid | output | 1 | Presented instruction is valid |
| ins_word | output | DW | Presented instruction word |
| ins_pc | output | AW | Address of the presented instruction |

## Verification
The bench builds the block with AW=6, DW=24 and DEPTH=4. The 64-word address space makes the wrap from 63 to 0 reachable within a short run. The 24-bit word checks that the generated contents are truncated consistently. Four buffer entries fill within a few cycles of stalling, so the full-buffer stop, the flush of a full pipeline and the five-word burst after a long stall are all reached quickly.

// File: rtl/ifetch_front.sv
module ifetch_front #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir,
  input  logic [AW-1:0] redir_pc,
  input  logic          be_ready,
  output logic          ins_valid,
  output logic [DW-1:0] ins_word,
  output logic [AW-1:0] ins_pc
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    logic [31:0] h;
    h = (32'(a) * 32'h9E37_79B9) ^ 32'h5A5A_5A5A;
    return DW'(h);
  endfunction

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic          clr;
  logic [AW-1:0] clr_pc;
  logic [AW-1:0] pc;
  logic          rd_vld;
  logic [AW-1:0] rd_pc;
  logic [DW-1:0] rd_word;
  logic [CW-1:0] cnt;
  logic [PW-1:0] wp, rp;
  logic [DW-1:0] q_word [DEPTH];
  logic [AW-1:0] q_pc   [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clr    <= 1'b1;
      clr_pc <= '0;
    end else begin
      clr    <= redir;
      clr_pc <= redir_pc;
    end

  wire [AW-1:0] fa    = clr ? clr_pc : pc;
  wire          issue = clr || ((CW+1)'(cnt) + (CW+1)'(rd_vld) < (CW+1)'(DEPTH));
  wire          push  = rd_vld && !clr;
  wire          empty = (cnt == '0);
  wire          take  = !empty && !clr && (!ins_valid || be_ready);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc      <= '0;
      rd_vld  <= 1'b0;
      rd_pc   <= '0;
      rd_word <= '0;
    end else begin
      rd_vld <= issue;
      if (issue) begin
        rd_pc   <= fa;
        rd_word <= rom_word(fa);
        pc      <= fa + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (take) rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(take);
    end

  always_ff @(posedge clk)
    if (push) begin
      q_word[wp] <= rd_word;
      q_pc[wp]   <= rd_pc;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ins_valid <= 1'b0;
      ins_word  <= '0;
      ins_pc    <= '0;
    end else if (clr) begin
      ins_valid <= 1'b0;
    end else if (take) begin
      ins_valid <= 1'b1;
      ins_word  <= q_word[rp];
      ins_pc    <= q_pc[rp];
    end else if (be_ready) begin
      ins_valid <= 1'b0;
    end
endmodule

// File: rtl/ifetch_front_chk.sv
module ifetch_front_chk #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic [$clog2(DEPTH+1)-1:0] cnt,
  input logic                       be_ready,
  input logic                       ins_valid,
  input logic [DW-1:0]              ins_word,
  input logic [AW-1:0]              ins_pc
);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
    logic [31:0] h;
    h = (32'(a) * 32'h9E37_79B9) ^ 32'h5A5A_5A5A;
    return DW'(h);
  endfunction

  a_r2_dark_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ins_valid);

  a_r2_valid_in_cycle4: assert property (@(posedge clk) disable iff (!rst_n)
    clr ##1 !clr ##1 !clr |=> ins_valid);

  a_r3_word_of_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_word == expect_word(ins_pc));

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !be_ready && !clr) |=> ins_valid && $stable(ins_word) && $stable(ins_pc));

  a_r4_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && be_ready && !clr) ##1 ins_valid |-> ins_pc == AW'($past(ins_pc) + 1'b1));

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

bind ifetch_front ifetch_front_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt), .be_ready(be_ready),
  .ins_valid(ins_valid), .ins_word(ins_word), .ins_pc(ins_pc)
);

// File: tb/sim_ifetch_front.sv
module sim_ifetch_front;
  localparam int AW = 6, DW = 24, DEPTH = 4;

  logic          clk = 1'b0, rst_n = 1'b0, redir = 1'b0, be_ready = 1'b0;
  logic [AW-1:0] redir_pc = '0;
  logic          ins_valid;
  logic [DW-1:0] ins_word;
  logic [AW-1:0] ins_pc;

  ifetch_front #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .redir(redir), .redir_pc(redir_pc), .be_ready(be_ready),
    .ins_valid(ins_valid), .ins_word(ins_word), .ins_pc(ins_pc)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0, mode = 0, cyc = 0;
  logic [AW-1:0] sb[$];
  logic [15:0]   lfsr = 16'hACE1;
  bit            hold_armed = 0;
  logic [AW-1:0] h_pc;
  logic [DW-1:0] h_word;

  function automatic logic [DW-1:0] spec_word(input logic [AW-1:0] a);
    logic [31:0] h;
    h = (32'(a) * 32'h9E37_79B9) ^ 32'h5A5A_5A5A;
    return DW'(h);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    be_ready = (mode == 1) ? (sb.size() > 0) :
               (mode == 2) ? (sb.size() > 0 && lfsr[0]) : 1'b0;
  end

  always @(negedge clk) begin
    logic [AW-1:0] e;
    cyc++;
    if (hold_armed) begin
      hold_armed = 0;
      check(ins_valid && ins_pc == h_pc && ins_word == h_word, "R5", "held pc",
            ins_pc, h_pc);
    end
    if (ins_valid && be_ready) begin
      if (sb.size() == 0) check(0, "R6", "unexpected accept", ins_pc, 0);
      else begin
        e = sb.pop_front();
        check(ins_pc == e, "R4", "accepted pc", ins_pc, e);
        check(ins_word == spec_word(e), "R3", "accepted word", ins_word, spec_word(e));
      end
    end else if (ins_valid && !be_ready && mode == 2) begin
      hold_armed = 1;
      h_pc = ins_pc;
      h_word = ins_word;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk)
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      finish_run();
    end

  task automatic push_run(input logic [AW-1:0] a, input int n);
    for (int i = 0; i < n; i++) sb.push_back(AW'(a + i));
  endtask

  task automatic run(input int m);
    mode = m;
    while (sb.size() > 0) @(negedge clk);
    mode = 0;
  endtask

  task automatic recover(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    @(negedge clk); check(!ins_valid, req, "valid in cycle 2", ins_valid, 0);
    @(negedge clk); check(!ins_valid, req, "valid in cycle 3", ins_valid, 0);
    @(negedge clk); check(ins_valid && ins_pc == a, req, "pc in cycle 4", ins_pc, a);
  endtask

  task automatic do_redirect(input logic [AW-1:0] a, input string req);
    @(posedge clk) #1; redir = 1; redir_pc = a;
    @(posedge clk) #1; redir = 0;
    recover(a, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!ins_valid, "R1", "valid in reset", ins_valid, 0);
    @(posedge clk) #1; rst_n = 1;
    recover('0, "R1");
    push_run('0, 10); run(1);

    do_redirect(6'd17, "R2");
    push_run(6'd17, 24); run(2);

    do_redirect(6'd61, "R8");
    push_run(6'd61, 8); run(1);

    do_redirect(6'd40, "R2");
    repeat (20) @(negedge clk);
    do_redirect(6'd5, "R7");
    repeat (20) @(negedge clk);
    push_run(6'd5, 9);
    mode = 1;
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge clk);
      check(ins_valid, "R10", "burst valid", ins_valid, 1);
    end
    run(1);

    @(posedge clk) #1; redir = 1; redir_pc = 6'd30;
    @(posedge clk) #1; redir_pc = 6'd12;
    @(posedge clk) #1; redir = 0;
    recover(6'd12, "R9");
    push_run(6'd12, 6); run(1);

    do_redirect(6'd50, "R2");
    push_run(6'd50, 30); run(2);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule